// File: doc/BRIEF.md
# Prescaled multi-mode timer counter

This block is a 16-bit timer counter with a register-style control port. One of four single-cycle clock-enable inputs is chosen as the count source. A shared prescaler divides that source by 1, 2, 4 or 8, and each divided tick advances the counter according to one of three counting profiles, or leaves it frozen. The profiles are: count up to a limit taken from an external compare input, run freely across the full 16-bit range, or rise and fall between zero and the limit.

Software writes a 9-bit control word that holds the mode, divider, source, a one-shot clear, the wrap interrupt enable and the wrap flag. The same word reads back, except that the clear bit always reads as 0. The counter can also be loaded and read directly. A wrap event sets a sticky flag. The interrupt line is raised while both the flag and the enable are 1.

Control word layout: bits [1:0] mode, [3:2] divider, [5:4] source, [6] clear, [7] wrap interrupt enable, [8] wrap flag.

Top module: `prescaled_timer`

## Requirements
- R1: Mode field: 00 halted, 01 up to limit, 10 free-running, 11 up/down. While halted, the counter and the prescaler hold their values whatever the source inputs do.
- R2: Divider field: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. The counter advances once per that many pulses of the selected source.
- R3: Source field value k (00 to 11) selects src_en_i[k]. Pulses on any other source input have no effect on the count.
- R4: In up mode the counter goes 0, 1, ... up to the limit and then back to 0, so one period is limit+1 ticks. The step from the limit back to 0 sets the wrap flag.
- R5: In up mode, if the count is above the limit when a tick arrives, the counter returns to 0 on that tick.
- R6: In free-running mode the counter goes from 0 up to 0xFFFF and wraps to 0, whatever the limit. The step from 0xFFFF to 0 sets the wrap flag.
- R7: In up/down mode the counter rises from 0 to the limit and then falls back to 0, and this repeats. Reaching 0 on the way down sets the wrap flag.
- R8: Writing the control word with bit 6 set zeroes the counter and the prescaler and sets the count direction to up. Bit 6 reads back as 0.
- R9: The wrap flag (bit 8) stays set until software writes 0 to it. A wrap event in the same cycle as a control write takes priority. irq_o is 1 exactly when the flag and the enable (bit 7) are both 1.
- R10: A count write loads cnt_wdata_i, and the value appears on cnt_o in the next cycle. A clear in the same cycle wins over the load.
- R11: A control write stores the mode, divider, source and enable fields, and they read back unchanged on ctrl_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 4 | Single-cycle count-source enables |
| limit_i | input | 16 | Terminal count for up and up/down modes |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 9 | Control word write data |
| ctrl_rdata_o | output | 9 | Control word readback |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write data |
| cnt_o | output | 16 | Current count |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
The hardest state to reach from the ports is a prescaler that is part-way through a divide-by-8 period, or a counter that is falling in up/down mode, at the moment a clear arrives. A wrong reset of either would only show up several pulses later. The stimulus builds up five pulses of prescaler progress and then clears. It checks that seven more pulses leave the count at 0 and that the eighth pulse moves it to 1. It also stops an up/down run on its falling slope, clears, and checks that the next tick counts upward. The free-running wrap is reached by loading 0xFFFE instead of waiting through 65536 ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_UPDN = 2'b11
  } mode_e;

  localparam int unsigned CTRL_W     = 9;
  localparam int unsigned MODE_LSB   = 0;
  localparam int unsigned DIV_LSB    = 2;
  localparam int unsigned SRC_LSB    = 4;
  localparam int unsigned CLR_BIT    = 6;
  localparam int unsigned IE_BIT     = 7;
  localparam int unsigned FLAG_BIT   = 8;
  localparam int unsigned FIELD_W    = 2;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CTRL_W-1:0]  wdata_i,
  input  logic               wrap_i,
  output mode_e              mode_o,
  output logic [FIELD_W-1:0] div_o,
  output logic [FIELD_W-1:0] src_o,
  output logic               clr_o,
  output logic               irq_o,
  output logic [CTRL_W-1:0]  rdata_o
);
  mode_e              mode_q;
  logic [FIELD_W-1:0] div_q, src_q;
  logic               ie_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_HALT;
      div_q  <= '0;
      src_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (we_i) begin
      mode_q <= mode_e'(wdata_i[MODE_LSB +: FIELD_W]);
      div_q  <= wdata_i[DIV_LSB +: FIELD_W];
      src_q  <= wdata_i[SRC_LSB +: FIELD_W];
      ie_q   <= wdata_i[IE_BIT];
      flag_q <= wdata_i[FLAG_BIT] | wrap_i;  // hardware set wins
    end else begin
      flag_q <= flag_q | wrap_i;
    end
  end

  assign clr_o  = we_i & wdata_i[CLR_BIT];
  assign mode_o = mode_q;
  assign div_o  = div_q;
  assign src_o  = src_q;
  assign irq_o  = flag_q & ie_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[MODE_LSB +: FIELD_W] = mode_q;
    rdata_o[DIV_LSB +: FIELD_W]  = div_q;
    rdata_o[SRC_LSB +: FIELD_W]  = src_q;
    rdata_o[IE_BIT]              = ie_q;
    rdata_o[FLAG_BIT]            = flag_q;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SRC_N = 4,
  parameter int unsigned DIV_W = 2,
  localparam int unsigned SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1,
  localparam int unsigned PS_W  = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [PS_W-1:0] ps_q, last;
  logic            src_tick;

  assign src_tick = (32'(sel_i) < SRC_N) ? src_en_i[sel_i] : 1'b0;
  assign last     = {PS_W{1'b1}} >> (PS_W - 32'(div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ps_q <= '0;
    else if (clr_i)              ps_q <= '0;
    else if (run_i && src_tick)  ps_q <= (ps_q == last) ? '0 : ps_q + 1'b1;
  end

  assign tick_o = run_i & src_tick & (ps_q == last) & ~clr_i;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d, wrap;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          if (cnt_q >= limit_i) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        MODE_FREE: begin
          cnt_d = cnt_q + 1'b1;
          wrap  = (cnt_q == CNT_MAX);
        end
        MODE_UPDN: begin
          if (!down_q) begin
            if (cnt_q >= limit_i) begin
              if (cnt_q <= CNT_ONE) begin
                cnt_d = '0;
                wrap  = (cnt_q == CNT_ONE);
              end else begin
                cnt_d  = cnt_q - 1'b1;
                down_d = 1'b1;
              end
            end else cnt_d = cnt_q + 1'b1;
          end else begin
            cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            if (cnt_q <= CNT_ONE) begin
              down_d = 1'b0;
              wrap   = (cnt_q == CNT_ONE);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap & ~clr_i & ~load_i;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SRC_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_en_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  mode_e              mode;
  logic [FIELD_W-1:0] div, src;
  logic               clr, tick, wrap;

  tmr_ctrl_regs u_regs (
    .clk_i, .rst_ni,
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .wrap_i  (wrap),
    .mode_o  (mode),
    .div_o   (div),
    .src_o   (src),
    .clr_o   (clr),
    .irq_o   (irq_o),
    .rdata_o (ctrl_rdata_o)
  );

  tmr_prescaler #(.SRC_N(SRC_N), .DIV_W(FIELD_W)) u_ps (
    .clk_i, .rst_ni,
    .src_en_i (src_en_i),
    .sel_i    (src),
    .div_i    (div),
    .run_i    (mode != MODE_HALT),
    .clr_i    (clr),
    .tick_o   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .mode_i     (mode),
    .limit_i    (limit_i),
    .clr_i      (clr),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_wdata_i),
    .cnt_o      (cnt_o),
    .wrap_o     (wrap)
  );
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SRC_N = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SRC_N-1:0] src_en_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             ctrl_we_i,
  input logic [8:0]       ctrl_wdata_i,
  input logic [8:0]       ctrl_rdata_o,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             irq_o
);
  logic quiet;
  assign quiet = !ctrl_we_i && !cnt_we_i;

  p_halt_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[1:0] == 2'b00 && quiet) |=> $stable(cnt_o));

  p_up_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[1:0] == 2'b01 && quiet && cnt_o <= limit_i) |=> cnt_o <= $past(limit_i));

  p_free_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[1:0] == 2'b10 && quiet)
      |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 16'd1));

  p_updn_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[1:0] == 2'b11 && quiet)
      |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 16'd1 || cnt_o == $past(cnt_o) - 16'd1));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[6]) |=> (cnt_o == '0 && !ctrl_rdata_o[6]));

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[8] && !ctrl_we_i) |=> ctrl_rdata_o[8]);

  p_irq_needs_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_rdata_o[7] && ctrl_rdata_o[8]));

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !(ctrl_we_i && ctrl_wdata_i[6])) |=> cnt_o == $past(cnt_wdata_i));
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .SRC_N(SRC_N)) u_chk (.*);

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src_en_i = '0;
  logic [15:0] limit_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic [8:0]  ctrl_wdata_i = '0;
  logic [8:0]  ctrl_rdata_o;
  logic        cnt_we_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0;
  logic [15:0] cnt_o;
  logic        irq_o;

  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  prescaled_timer uut (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  div;
    logic [1:0]  src;
    logic [1:0]  psrc;
    logic [15:0] limit;
    logic [7:0]  pulses;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'b01, 2'b00, 2'b00, 2'b00, 16'd4, 8'd7,  16'd2, 1'b1},
    '{2'b01, 2'b01, 2'b01, 2'b01, 16'd4, 8'd6,  16'd3, 1'b0},
    '{2'b01, 2'b10, 2'b10, 2'b10, 16'd2, 8'd12, 16'd0, 1'b1},
    '{2'b11, 2'b00, 2'b11, 2'b11, 16'd3, 8'd5,  16'd1, 1'b0},
    '{2'b11, 2'b00, 2'b11, 2'b11, 16'd3, 8'd6,  16'd0, 1'b1},
    '{2'b11, 2'b00, 2'b11, 2'b11, 16'd3, 8'd8,  16'd2, 1'b1},
    '{2'b10, 2'b11, 2'b00, 2'b00, 16'd1, 8'd24, 16'd3, 1'b0},
    '{2'b00, 2'b00, 2'b00, 2'b00, 16'd4, 8'd10, 16'd0, 1'b0},
    '{2'b01, 2'b00, 2'b01, 2'b00, 16'd4, 8'd5,  16'd0, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R4";
      1: return "R2 R3";
      2: return "R2 R4";
      3, 4, 5: return "R7";
      6: return "R6 R2";
      7: return "R1";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [1:0] mode, logic [1:0] div, logic [1:0] src,
                         logic clr, logic ie, logic flag);
    @(negedge clk_i);
    ctrl_we_i    = 1'b1;
    ctrl_wdata_i = {flag, ie, clr, src, div, mode};
    @(negedge clk_i);
    ctrl_we_i    = 1'b0;
  endtask

  task automatic wr_cnt(logic [15:0] v);
    @(negedge clk_i);
    cnt_we_i    = 1'b1;
    cnt_wdata_i = v;
    @(negedge clk_i);
    cnt_we_i    = 1'b0;
  endtask

  task automatic pulse(logic [1:0] s, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      src_en_i = 4'b0001 << s;
      @(negedge clk_i);
      src_en_i = '0;
    end
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset count", 32'(cnt_o), 0);
    check("R11 reset ctrl", 32'(ctrl_rdata_o), 0);
    check("R9 reset irq", 32'(irq_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 9; i++) begin
      limit_i = VEC[i].limit;
      wr_ctrl(VEC[i].mode, VEC[i].div, VEC[i].src, 1'b1, 1'b0, 1'b0);
      pulse(VEC[i].psrc, int'(VEC[i].pulses));
      check({vtag(i), " vector count"}, 32'(cnt_o), 32'(VEC[i].exp_cnt));
      check({vtag(i), " vector flag"}, 32'(ctrl_rdata_o[8]), 32'(VEC[i].exp_flag));
    end

    // R11 readback, R8 clear reads 0
    wr_ctrl(2'b01, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0);
    check("R11 R8 ctrl readback", 32'(ctrl_rdata_o), 32'(9'b0_1_0_10_11_01));

    // R10 count load
    wr_cnt(16'h1234);
    check("R10 load", 32'(cnt_o), 32'h1234);

    // R5 limit dropped below count
    limit_i = 16'd10;
    wr_ctrl(2'b01, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    wr_cnt(16'd8);
    limit_i = 16'd3;
    pulse(2'd0, 1);
    check("R5 return to zero", 32'(cnt_o), 0);

    // R6 wrap at 0xFFFF with limit ignored, R9 flag and irq
    limit_i = 16'd5;
    wr_ctrl(2'b10, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    wr_cnt(16'hFFFE);
    pulse(2'd0, 1);
    check("R6 reach max", 32'(cnt_o), 32'hFFFF);
    check("R6 no flag before wrap", 32'(ctrl_rdata_o[8]), 0);
    pulse(2'd0, 1);
    check("R6 wrap to zero", 32'(cnt_o), 0);
    check("R9 flag set", 32'(ctrl_rdata_o[8]), 1);
    check("R9 irq masked", 32'(irq_o), 0);
    wr_ctrl(2'b10, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
    check("R9 irq raised", 32'(irq_o), 1);
    pulse(2'd0, 3);
    check("R9 flag sticky", 32'(ctrl_rdata_o[8]), 1);
    wr_ctrl(2'b10, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    check("R9 flag cleared", 32'(ctrl_rdata_o[8]), 0);
    check("R9 irq dropped", 32'(irq_o), 0);

    // R8 prescaler cleared mid-period
    wr_ctrl(2'b01, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    limit_i = 16'd100;
    pulse(2'd0, 5);
    wr_ctrl(2'b01, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    pulse(2'd0, 7);
    check("R8 prescaler reset", 32'(cnt_o), 0);
    pulse(2'd0, 1);
    check("R8 first tick after clear", 32'(cnt_o), 1);

    // R8 direction cleared on the falling slope
    limit_i = 16'd3;
    wr_ctrl(2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    pulse(2'd0, 4);
    check("R7 falling", 32'(cnt_o), 2);
    wr_ctrl(2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
    pulse(2'd0, 1);
    check("R8 direction up", 32'(cnt_o), 1);

    // R1 halted: count write holds, pulses ignored
    wr_ctrl(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
    pulse(2'd0, 4);
    check("R1 halted hold", 32'(cnt_o), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule